// File: doc/BRIEF.md
# Handshaked Timer Clock Controller

This block picks and gates the clock that drives a low-power timer's prescaler and counter. Software sees three small registers. The clock register holds a source-select bit and a clock-enable bit. The status view shows a busy flag. The control register holds a counter-enable bit. Two sources can be chosen: a general-purpose clock, or a 1 kHz clock derived from a 32 kHz oscillator. The 1 kHz source only counts as present while the oscillator runs in crystal mode.

Both source clocks enter as levels and are oversampled by the bus clock. Each accepted clock-register write flips a request toggle. That toggle crosses into the selected source's timing through a two-stage synchroniser that advances only on that source's rising edges. There the new setting is applied, and an acknowledge toggle returns through a two-stage synchroniser in the bus clock. Busy covers the whole round trip. Software must wait for busy to clear before the next clock-register write.

The enable order is: write the select value, wait, set the enable bit with the select unchanged, wait. Disabling is a single write that clears the enable bit with the select unchanged, then a wait. The gated clock switches only while the sources involved are low. A debug-halt input freezes the prescaler and counter unless two run-in-debug qualifiers are both set.

Top module: `tclk_ctrl`

## Requirements
- R1: After synchronous reset, select=0, clock enable=0, busy=0, counter enable=0, tick=0, gated clock=0 and count=0.
- R2: The select bit encodes 0 = general-purpose clock and 1 = 1 kHz clock. A clock-register write that would change both the select bit and the enable bit is ignored: busy stays low and neither bit changes.
- R3: Any other clock-register write made while busy is low stores both bits and raises busy on the next cycle. A clock-register write made while busy is high is ignored.
- R4: An accepted setting takes effect at the third rising edge of the selected source seen after the write. Busy falls exactly three bus cycles after that edge. While the selected source is stopped, busy stays high.
- R5: The gated clock output equals the active source level while the active enable is set, and is 0 otherwise. The active source and enable of the output stage change only on a cycle where both the currently used source and the newly requested source are low.
- R6: The 1 kHz source is treated as held low unless crystal mode is asserted. Selecting it without crystal mode leaves busy high and the gated clock low.
- R7: The 16-bit prescaler advances on each rising edge of the gated clock. A tick pulse lasting one cycle is produced on every 2^TAP-th advance (TAP=2 by default, so every fourth edge).
- R8: The 32-bit counter increments on each tick while the counter-enable bit is set, and holds its value while that bit is clear.
- R9: While debug halt is asserted, the prescaler and counter hold and no tick occurs, unless both the global and the per-timer run-in-debug inputs are set.
- R10: Setting the counter-enable bit while the clock enable is off leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| src_gen_i | input | 1 | General-purpose source clock level |
| src_lf_i | input | 1 | 1 kHz source clock level |
| xtal_mode_i | input | 1 | Oscillator is in crystal mode |
| wr_clk_i | input | 1 | Clock register write strobe |
| wr_sel_i | input | 1 | Written source select |
| wr_en_i | input | 1 | Written clock enable |
| wr_ctl_i | input | 1 | Control register write strobe |
| wr_cnt_en_i | input | 1 | Written counter enable |
| dbg_halt_i | input | 1 | CPU halted in debug |
| dbg_run_global_i | input | 1 | Global run-in-debug qualifier |
| dbg_run_periph_i | input | 1 | Per-timer run-in-debug qualifier |
| clk_sel_o | output | 1 | Clock register select readback |
| clk_en_o | output | 1 | Clock register enable readback |
| busy_o | output | 1 | Clock register update in progress |
| cnt_en_o | output | 1 | Control register counter enable readback |
| gclk_o | output | 1 | Gated, selected timer clock |
| tick_o | output | 1 | Prescaler tap pulse |
| count_o | output | 32 | Timer count |

## Verification
An accepted write shows up on the register readbacks and on busy one cycle after the strobe edge. The new source and enable are applied at the third qualifying source edge. Busy drops three bus cycles after that. Prescaler ticks and counter steps appear one cycle after the gated source edge that causes them, and the gated clock follows the source level in the same cycle. The bench advances a behavioural model at each rising edge from the same inputs and compares every output at the falling edge, so each result is checked in the cycle it is due. Directed checks are made at fixed offsets after write strobes, for the stalled-source, freeze and missing-crystal cases.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

    typedef enum logic {
        SRC_GEN = 1'b0,
        SRC_LF  = 1'b1
    } src_e;

    typedef struct packed {
        src_e sel;
        logic en;
    } clk_cfg_t;

    typedef struct packed {
        logic gen;
        logic lf;
    } src_pair_t;

    function automatic logic pick_src(input src_e s, input src_pair_t p);
        return (s == SRC_LF) ? p.lf : p.gen;
    endfunction

    function automatic logic dual_change(input clk_cfg_t cur, input clk_cfg_t nxt);
        return (cur.sel != nxt.sel) && (cur.en != nxt.en);
    endfunction

endpackage

// File: rtl/tclk_sync.sv
module tclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)      chain <= '0;
                else if (adv) chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)      chain <= '0;
                else if (adv) chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tclk_bus_regs.sv
module tclk_bus_regs
    import tclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  clk_cfg_t wr_cfg,
    input  logic     ack_s,
    output clk_cfg_t cfg,
    output logic     busy,
    output logic     req
);
    logic accept;

    // a write is taken only when idle and not flipping both fields
    assign accept = wr && !busy && !dual_change(cfg, wr_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '{sel: SRC_GEN, en: 1'b0};
            busy <= 1'b0;
            req  <= 1'b0;
        end else if (accept) begin
            cfg  <= wr_cfg;
            busy <= 1'b1;
            req  <= ~req;
        end else if (busy && (ack_s == req)) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/tclk_dom_apply.sv
module tclk_dom_apply
    import tclk_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t sw_cfg,
    input  logic     req,
    input  logic     src_rise,
    output clk_cfg_t act,
    output logic     ack
);
    logic req_s;

    // request toggle advances only on edges of the chosen source
    tclk_sync #(.STAGES(STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .adv (src_rise),
        .d   (req),
        .q   (req_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '{sel: SRC_GEN, en: 1'b0};
            ack <= 1'b0;
        end else if (src_rise && (req_s != ack)) begin
            act <= sw_cfg;
            ack <= req_s;
        end
    end
endmodule

// File: rtl/tclk_gate.sv
module tclk_gate
    import tclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_pair_t lvl,
    input  src_pair_t rise,
    input  clk_cfg_t  act,
    output src_e      o_sel,
    output logic      o_on,
    output logic      gclk,
    output logic      pulse
);
    logic cur_low;
    logic nxt_low;

    assign cur_low = !pick_src(o_sel, lvl);
    assign nxt_low = !pick_src(act.sel, lvl);

    // switch only with both involved sources low: no short phase
    always_ff @(posedge clk) begin
        if (rst) begin
            o_sel <= SRC_GEN;
            o_on  <= 1'b0;
        end else if (cur_low && nxt_low) begin
            o_sel <= act.sel;
            o_on  <= act.en;
        end
    end

    assign gclk  = o_on & pick_src(o_sel, lvl);
    assign pulse = o_on & pick_src(o_sel, rise);
endmodule

// File: rtl/tclk_prescale.sv
module tclk_prescale #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 32,
    parameter int TAP   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    input  logic             freeze,
    input  logic             cnt_en,
    output logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [PRE_W-1:0] TAP_MASK = {PRE_W{1'b1}} >> (PRE_W - TAP);

    logic [PRE_W-1:0] pre;
    logic             run;
    logic             wrap;

    assign run  = pulse & ~freeze;
    assign wrap = (pre & TAP_MASK) == TAP_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre   <= '0;
            tick  <= 1'b0;
            count <= '0;
        end else begin
            tick <= run && wrap;
            if (run) pre <= pre + 1'b1;
            if (run && wrap && cnt_en) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tclk_ctrl.sv
module tclk_ctrl
    import tclk_pkg::*;
#(
    parameter int PRE_W       = 16,
    parameter int CNT_W       = 32,
    parameter int TAP         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_gen_i,
    input  logic             src_lf_i,
    input  logic             xtal_mode_i,
    input  logic             wr_clk_i,
    input  logic             wr_sel_i,
    input  logic             wr_en_i,
    input  logic             wr_ctl_i,
    input  logic             wr_cnt_en_i,
    input  logic             dbg_halt_i,
    input  logic             dbg_run_global_i,
    input  logic             dbg_run_periph_i,
    output logic             clk_sel_o,
    output logic             clk_en_o,
    output logic             busy_o,
    output logic             cnt_en_o,
    output logic             gclk_o,
    output logic             tick_o,
    output logic [CNT_W-1:0] count_o
);
    src_pair_t lvl;
    src_pair_t lvl_q;
    src_pair_t rise;
    clk_cfg_t  wr_cfg;
    clk_cfg_t  sw_cfg;
    clk_cfg_t  act_cfg;
    logic      req;
    logic      ack;
    logic      ack_s;
    logic      sel_rise;
    logic      gate_on;
    src_e      gate_sel;
    logic      gpulse;
    logic      freeze;
    logic      cnt_en_q;

    // oscillator-derived source is absent outside crystal mode
    assign lvl  = '{gen: src_gen_i, lf: src_lf_i & xtal_mode_i};
    assign rise = lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign wr_cfg = '{sel: src_e'(wr_sel_i), en: wr_en_i};

    tclk_bus_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_clk_i),
        .wr_cfg (wr_cfg),
        .ack_s  (ack_s),
        .cfg    (sw_cfg),
        .busy   (busy_o),
        .req    (req)
    );

    assign sel_rise = pick_src(sw_cfg.sel, rise);

    tclk_dom_apply #(.STAGES(SYNC_STAGES)) u_apply (
        .clk      (clk),
        .rst      (rst),
        .sw_cfg   (sw_cfg),
        .req      (req),
        .src_rise (sel_rise),
        .act      (act_cfg),
        .ack      (ack)
    );

    tclk_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .adv (1'b1),
        .d   (ack),
        .q   (ack_s)
    );

    tclk_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl),
        .rise  (rise),
        .act   (act_cfg),
        .o_sel (gate_sel),
        .o_on  (gate_on),
        .gclk  (gclk_o),
        .pulse (gpulse)
    );

    always_ff @(posedge clk) begin
        if (rst)           cnt_en_q <= 1'b0;
        else if (wr_ctl_i) cnt_en_q <= wr_cnt_en_i;
    end

    assign freeze = dbg_halt_i & ~(dbg_run_global_i & dbg_run_periph_i);

    tclk_prescale #(.PRE_W(PRE_W), .CNT_W(CNT_W), .TAP(TAP)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .pulse  (gpulse),
        .freeze (freeze),
        .cnt_en (cnt_en_q),
        .tick   (tick_o),
        .count  (count_o)
    );

    assign clk_sel_o = sw_cfg.sel;
    assign clk_en_o  = sw_cfg.en;
    assign cnt_en_o  = cnt_en_q;
endmodule

// File: rtl/tclk_ctrl_chk.sv
module tclk_ctrl_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_clk_i,
    input logic             wr_sel_i,
    input logic             wr_en_i,
    input logic             busy_o,
    input logic             clk_sel_o,
    input logic             clk_en_o,
    input logic             cnt_en_o,
    input logic             gate_on,
    input logic             gate_sel,
    input logic             src_gen_i,
    input logic             src_lf_i,
    input logic             xtal_mode_i,
    input logic             dbg_halt_i,
    input logic             dbg_run_global_i,
    input logic             dbg_run_periph_i,
    input logic             tick_o,
    input logic [CNT_W-1:0] count_o
);
    logic used_lvl;
    assign used_lvl = gate_sel ? (src_lf_i & xtal_mode_i) : src_gen_i;

    AST_DUAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_clk_i && !busy_o && (wr_sel_i != clk_sel_o) && (wr_en_i != clk_en_o))
        |=> (!busy_o && $stable(clk_sel_o) && $stable(clk_en_o))); // R2

    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (wr_clk_i && !busy_o && !((wr_sel_i != clk_sel_o) && (wr_en_i != clk_en_o)))
        |=> (busy_o && (clk_sel_o == $past(wr_sel_i)) && (clk_en_o == $past(wr_en_i)))); // R3

    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ($stable(clk_sel_o) && $stable(clk_en_o))); // R3

    AST_GATE_SWITCH_LOW: assert property (@(posedge clk) disable iff (rst)
        used_lvl |=> ($stable(gate_on) && $stable(gate_sel))); // R5

    AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !gate_on |=> !tick_o); // R10

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt_i && !(dbg_run_global_i && dbg_run_periph_i))
        |=> ($stable(count_o) && !tick_o)); // R9

    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        !cnt_en_o |=> $stable(count_o)); // R8

    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (count_o != $past(count_o)) |-> (tick_o && (count_o == $past(count_o) + 1'b1))); // R8
endmodule

bind tclk_ctrl tclk_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .wr_clk_i         (wr_clk_i),
    .wr_sel_i         (wr_sel_i),
    .wr_en_i          (wr_en_i),
    .busy_o           (busy_o),
    .clk_sel_o        (clk_sel_o),
    .clk_en_o         (clk_en_o),
    .cnt_en_o         (cnt_en_o),
    .gate_on          (gate_on),
    .gate_sel         (gate_sel),
    .src_gen_i        (src_gen_i),
    .src_lf_i         (src_lf_i),
    .xtal_mode_i      (xtal_mode_i),
    .dbg_halt_i       (dbg_halt_i),
    .dbg_run_global_i (dbg_run_global_i),
    .dbg_run_periph_i (dbg_run_periph_i),
    .tick_o           (tick_o),
    .count_o          (count_o)
);

// File: tb/tclk_ctrl_tb.sv
module tclk_ctrl_tb;
    localparam int TAP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_gen_i = 1'b0, src_lf_i = 1'b0, xtal_mode_i = 1'b1;
    logic        wr_clk_i = 1'b0, wr_sel_i = 1'b0, wr_en_i = 1'b0;
    logic        wr_ctl_i = 1'b0, wr_cnt_en_i = 1'b0;
    logic        dbg_halt_i = 1'b0, dbg_run_global_i = 1'b0, dbg_run_periph_i = 1'b0;
    logic        clk_sel_o, clk_en_o, busy_o, cnt_en_o, gclk_o, tick_o;
    logic [31:0] count_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tclk_ctrl #(.PRE_W(16), .CNT_W(32), .TAP(TAP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .src_gen_i(src_gen_i), .src_lf_i(src_lf_i),
        .xtal_mode_i(xtal_mode_i), .wr_clk_i(wr_clk_i), .wr_sel_i(wr_sel_i),
        .wr_en_i(wr_en_i), .wr_ctl_i(wr_ctl_i), .wr_cnt_en_i(wr_cnt_en_i),
        .dbg_halt_i(dbg_halt_i), .dbg_run_global_i(dbg_run_global_i),
        .dbg_run_periph_i(dbg_run_periph_i), .clk_sel_o(clk_sel_o),
        .clk_en_o(clk_en_o), .busy_o(busy_o), .cnt_en_o(cnt_en_o),
        .gclk_o(gclk_o), .tick_o(tick_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // source level generators: general period 4, slow period 10
    bit gen_run = 1, lf_run = 1;
    int gen_ph = 0, lf_ph = 0;
    always @(posedge clk) begin
        #1;
        if (gen_run) begin gen_ph = (gen_ph + 1) % 4; src_gen_i = (gen_ph >= 2); end
        else src_gen_i = 1'b0;
        if (lf_run) begin lf_ph = (lf_ph + 1) % 10; src_lf_i = (lf_ph >= 5); end
        else src_lf_i = 1'b0;
    end

    // behavioural reference model, advanced at every rising edge
    bit        started = 0;
    bit        m_sel, m_en, m_busy, m_wait_ack, m_asel, m_aen, m_osel, m_on;
    bit        m_pgen, m_plf, m_tick, m_cnten;
    int        m_n, m_pre;
    bit [31:0] m_count;
    bit        lg, ll, rg, rl, rsel, lo, la, pe, frz, run;

    always @(posedge clk) begin
        if (rst) begin
            started = 1;
            m_sel = 0; m_en = 0; m_busy = 0; m_wait_ack = 0; m_asel = 0; m_aen = 0;
            m_osel = 0; m_on = 0; m_pgen = 0; m_plf = 0; m_tick = 0; m_cnten = 0;
            m_n = 0; m_pre = 0; m_count = 0;
        end else begin
            lg   = src_gen_i;
            ll   = src_lf_i & xtal_mode_i;
            rg   = lg && !m_pgen;
            rl   = ll && !m_plf;
            rsel = m_sel ? rl : rg;
            lo   = m_osel ? ll : lg;
            la   = m_asel ? ll : lg;
            pe   = m_on && (m_osel ? rl : rg);
            frz  = dbg_halt_i && !(dbg_run_global_i && dbg_run_periph_i);
            run  = pe && !frz;
            if (run) begin
                m_tick = ((m_pre % (1 << TAP)) == ((1 << TAP) - 1));
                if (m_tick && m_cnten) m_count = m_count + 1;
                m_pre = (m_pre + 1) % 65536;
            end else m_tick = 0;
            if (!lo && !la) begin m_osel = m_asel; m_on = m_aen; end
            if (m_busy) begin
                if (!m_wait_ack) begin
                    if (rsel) begin
                        m_n++;
                        if (m_n == 3) begin m_asel = m_sel; m_aen = m_en; m_wait_ack = 1; m_n = 0; end
                    end
                end else begin
                    m_n++;
                    if (m_n == 3) begin m_busy = 0; m_wait_ack = 0; m_n = 0; end
                end
            end else if (wr_clk_i && !((wr_sel_i != m_sel) && (wr_en_i != m_en))) begin
                m_sel = wr_sel_i; m_en = wr_en_i; m_busy = 1; m_wait_ack = 0; m_n = 0;
            end
            if (wr_ctl_i) m_cnten = wr_cnt_en_i;
            m_pgen = lg;
            m_plf  = ll;
        end
    end

    always @(negedge clk) begin
        if (started && !rst && !done) begin
            chk(busy_o == m_busy, "R4 busy timing", 32'(busy_o), 32'(m_busy));
            chk({clk_sel_o, clk_en_o} == {m_sel, m_en}, "R2 clock register", 32'({clk_sel_o, clk_en_o}), 32'({m_sel, m_en}));
            chk(gclk_o == (m_on && (m_osel ? (src_lf_i & xtal_mode_i) : src_gen_i)), "R5 gated clock",
                32'(gclk_o), 32'(m_on && (m_osel ? (src_lf_i & xtal_mode_i) : src_gen_i)));
            chk(tick_o == m_tick, "R7 tick", 32'(tick_o), 32'(m_tick));
            chk(count_o == m_count, "R8 count", count_o, m_count);
            chk(cnt_en_o == m_cnten, "R10 counter enable", 32'(cnt_en_o), 32'(m_cnten));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input bit sel, input bit en);
        wr_clk_i = 1'b1; wr_sel_i = sel; wr_en_i = en;
        step();
        wr_clk_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy_o; i++) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    logic [31:0] c0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step();
        // R1 reset state
        chk({clk_sel_o, clk_en_o, busy_o, cnt_en_o, tick_o} == 5'b0, "R1 reset flags",
            32'({clk_sel_o, clk_en_o, busy_o, cnt_en_o, tick_o}), 0);
        chk(count_o == 0, "R1 reset count", count_o, 0);
        chk(gclk_o == 1'b0, "R1 reset gated clock", 32'(gclk_o), 0);

        // R10 counter enabled while clock still off
        wr_ctl_i = 1; wr_cnt_en_i = 1; step(); wr_ctl_i = 0;
        repeat (30) step();
        chk(count_o == 0, "R10 no count without clock", count_o, 0);

        // R2 write flipping both fields
        do_write(1'b1, 1'b1);
        chk(busy_o == 1'b0, "R2 dual write no busy", 32'(busy_o), 0);
        chk({clk_sel_o, clk_en_o} == 2'b00, "R2 dual write ignored", 32'({clk_sel_o, clk_en_o}), 0);

        // R3 enable sequence step one, then a write during busy
        do_write(1'b0, 1'b0);
        chk(busy_o == 1'b1, "R3 busy after write", 32'(busy_o), 1);
        do_write(1'b1, 1'b0);
        chk(clk_sel_o == 1'b0, "R3 write while busy ignored", 32'(clk_sel_o), 0);
        wait_idle();
        chk(clk_sel_o == 1'b0, "R3 select after busy", 32'(clk_sel_o), 0);

        // R4 stalled source keeps busy
        gen_run = 0; step(); step();
        do_write(1'b0, 1'b1);
        repeat (20) step();
        chk(busy_o == 1'b1, "R4 busy held without source edges", 32'(busy_o), 1);
        gen_run = 1;
        wait_idle();
        chk(busy_o == 1'b0, "R4 busy clears after edges", 32'(busy_o), 0);
        repeat (60) step();
        chk(count_o > 0, "R8 counter running", count_o, 1);

        // R9 freeze with only one qualifier
        dbg_halt_i = 1; dbg_run_global_i = 1; dbg_run_periph_i = 0;
        step(); c0 = count_o;
        repeat (40) step();
        chk(count_o == c0, "R9 frozen count", count_o, c0);
        dbg_run_periph_i = 1;
        repeat (40) step();
        chk(count_o > c0, "R9 runs with both qualifiers", count_o, c0 + 1);
        dbg_halt_i = 0;

        // R8 counter enable cleared
        wr_ctl_i = 1; wr_cnt_en_i = 0; step(); wr_ctl_i = 0;
        c0 = count_o;
        repeat (30) step();
        chk(count_o == c0, "R8 hold while disabled", count_o, c0);
        wr_ctl_i = 1; wr_cnt_en_i = 1; step(); wr_ctl_i = 0;

        // disable, move to slow source, enable
        do_write(1'b0, 1'b0); wait_idle();
        do_write(1'b1, 1'b0); wait_idle();
        do_write(1'b1, 1'b1); wait_idle();
        chk({clk_sel_o, clk_en_o} == 2'b11, "R3 slow source enabled", 32'({clk_sel_o, clk_en_o}), 3);
        c0 = count_o;
        repeat (160) step();
        chk(count_o > c0, "R7 slow source counts", count_o, c0 + 1);

        // R6 slow source without crystal mode
        rst = 1; step(); step(); rst = 0; xtal_mode_i = 0;
        do_write(1'b1, 1'b0); wait_idle();
        chk(busy_o == 1'b1, "R6 busy stuck without crystal", 32'(busy_o), 1);
        do_write(1'b1, 1'b1);
        repeat (20) step();
        chk(count_o == 0, "R6 no count without crystal", count_o, 0);

        report();
    end
endmodule